// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This controller sits next to a processor core and decides when the core must leave its instruction stream for a handler, and where it lands when it comes back. Seven prioritised device lines, a synchronous exception port and a trap port compete for entry. An accepted entry is one atomic step. The core PC is saved, the global enable is cleared, the mode switches to supervisor and the fetch unit gets a vector target. The current priority level, enable and mode are kept on a four-entry last-in first-out stack, so each handler returns to exactly the context it interrupted.

Device `i` is fixed at level `i+1`, so a higher index is more urgent. Level 0 means plain user code. A running handler can only be preempted by a strictly more urgent device, and only after software has set the global enable again. Exceptions and traps ignore the enable, the mask and the level. A small register port, writable only in supervisor mode, sets the enable, overwrites the level, clears pending bits and loads the device mask. A return strobe pops the stack and hands the saved PC back to the core.

Top module: `nest_irq_ctl`

## Requirements
- R1: After reset the block is in user mode with the global enable off, level 0, stack depth 0, no pending bits, mask clear, overflow flag low and no redirect.
- R2: A device line that is high at a clock edge sets its pending bit at that edge. A pending bit stays set until a supervisor write to address 2 with data bit `i` high clears it, and it is set again at once if the line is still high.
- R3: Device `i` has level `i+1`. It is accepted when its pending bit is set, mask bit `i` is set (address 3), the global enable is on and `i+1` is strictly greater than the current level. Among accepted devices the highest index wins, with its redirect one edge after the pending bit becomes visible.
- R4: An entry updates all of these at one edge: redirect valid, redirect PC = 0x100 + 4 × cause index, supervisor mode, global enable off, depth + 1, and, for a device, level = device level. The saved context is the PC input, the level, the enable and the mode from before the entry.
- R5: An exception uses cause index 7 + exception code and a trap uses 11 + trap number. An exception wins over a trap, and a trap wins over any device. Neither is blocked by the enable, the mask or the level, and neither changes the level. Each is redirected at the edge that samples it.
- R6: A return strobe with depth > 0 pops the stack at the next edge. It gives a redirect with the saved PC and restores level, enable and mode. With depth 0 a return is ignored. A return takes precedence over any entry in the same cycle.
- R7: In supervisor mode a write sets the enable from data bit 0 (address 0), sets the level from data bits 2:0 (address 1), clears pending bits (address 2) or loads the mask (address 3). A write is dropped in any cycle that carries a return strobe or an entry request, including a refused one.
- R8: Register writes made in user mode change nothing.
- R9: The stack holds four entries. An entry request while it is full is not taken, and it sets an overflow flag that stays high until reset.
- R10: A device at the same level as the running handler is held pending, while a more urgent device preempts the handler once the enable is on again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_req | input | 7 | Level-sensitive device request lines |
| exc_valid | input | 1 | Synchronous exception present |
| exc_cause | input | 2 | Exception code |
| trap_valid | input | 1 | Trap instruction present |
| trap_num | input | 2 | Trap number |
| cur_pc | input | 32 | PC to save on entry |
| rte | input | 1 | Return-from-exception strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 7 | Register write data |
| redir_valid | output | 1 | Fetch redirect this cycle |
| redir_pc | output | 32 | Vector target or saved return PC |
| sup_mode | output | 1 | 1 = supervisor mode |
| gie | output | 1 | Global interrupt enable |
| level | output | 3 | Current priority level |
| depth | output | 3 | Stack depth |
| pend | output | 7 | Pending device bits |
| ovf | output | 1 | Sticky stack overflow flag |

## Verification
The assertions check on every cycle that depth never exceeds four, that overflow is sticky, that a nonzero depth implies supervisor mode, and that user mode always runs at level 0. They also check that every depth increase comes with a redirect, supervisor mode and a cleared enable, that every redirect moves the depth, and that a user-mode write leaves the enable alone. The exact vector address for each cause, the precedence between exceptions, traps and devices, and the restore of the saved PC and level on return can only be shown by the bench scenarios. The same holds for same-level blocking against more-urgent preemption, and for writes being dropped in the cycle of an entry.

// File: rtl/nest_irq_ctl.sv
module nest_irq_ctl #(
  parameter int NDEV = 7,
  parameter int NEXC = 4,
  parameter int NTRAP = 4,
  parameter int PCW = 32,
  parameter int DEPTH = 4,
  parameter logic [PCW-1:0] VEC_BASE = 'h100,
  localparam int EXCW = $clog2(NEXC),
  localparam int TRPW = $clog2(NTRAP),
  localparam int DPW = $clog2(DEPTH + 1),
  localparam int WDW = (NDEV > 3) ? NDEV : 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NDEV-1:0] dev_req,
  input  logic            exc_valid,
  input  logic [EXCW-1:0] exc_cause,
  input  logic            trap_valid,
  input  logic [TRPW-1:0] trap_num,
  input  logic [PCW-1:0]  cur_pc,
  input  logic            rte,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [WDW-1:0]  wr_data,
  output logic            redir_valid,
  output logic [PCW-1:0]  redir_pc,
  output logic            sup_mode,
  output logic            gie,
  output logic [2:0]      level,
  output logic [DPW-1:0]  depth,
  output logic [NDEV-1:0] pend,
  output logic            ovf
);
  localparam int DIW = $clog2(NDEV);
  localparam int CW = $clog2(NDEV + NEXC + NTRAP);
  localparam int AW = $clog2(DEPTH);

  logic [NDEV-1:0] mask_q;
  logic [PCW-1:0] s_pc [DEPTH];
  logic [2:0] s_lvl [DEPTH];
  logic [DEPTH-1:0] s_sup, s_gie;

  logic dev_hit;
  logic [DIW-1:0] dev_idx;
  always_comb begin
    dev_hit = 1'b0;
    dev_idx = '0;
    for (int i = 0; i < NDEV; i++)
      if (pend[i] && mask_q[i] && gie && (3'(i + 1) > level)) begin
        dev_hit = 1'b1;
        dev_idx = DIW'(i);
      end
  end

  wire want  = exc_valid | trap_valid | dev_hit;
  wire full  = depth == DPW'(DEPTH);
  wire pop   = rte && depth != '0;
  wire push  = !rte && want && !full;
  wire wr_ok = wr_en && sup_mode && !rte && !want;
  wire [AW-1:0] wp = AW'(depth);
  wire [AW-1:0] rp = AW'(depth - DPW'(1));
  wire [NDEV-1:0] clr = (wr_ok && wr_addr == 2'd2) ? wr_data[NDEV-1:0] : '0;

  logic [CW-1:0] cause;
  always_comb
    if (exc_valid)       cause = CW'(NDEV) + CW'(exc_cause);
    else if (trap_valid) cause = CW'(NDEV + NEXC) + CW'(trap_num);
    else                 cause = CW'(dev_idx);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      redir_valid <= 1'b0;
      redir_pc    <= '0;
      sup_mode    <= 1'b0;
      gie         <= 1'b0;
      level       <= '0;
      depth       <= '0;
      pend        <= '0;
      mask_q      <= '0;
      ovf         <= 1'b0;
    end else begin
      redir_valid <= pop | push;
      pend <= (pend & ~clr) | dev_req;
      if (!rte && want && full) ovf <= 1'b1;
      if (pop) begin
        redir_pc <= s_pc[rp];
        level    <= s_lvl[rp];
        sup_mode <= s_sup[rp];
        gie      <= s_gie[rp];
        depth    <= depth - DPW'(1);
      end else if (push) begin
        redir_pc <= VEC_BASE + (PCW'(cause) << 2);
        sup_mode <= 1'b1;
        gie      <= 1'b0;
        depth    <= depth + DPW'(1);
        if (!exc_valid && !trap_valid) level <= 3'(dev_idx) + 3'd1;
      end else if (wr_ok) begin
        case (wr_addr)
          2'd0: gie <= wr_data[0];
          2'd1: level <= wr_data[2:0];
          2'd3: mask_q <= wr_data[NDEV-1:0];
          default: ;
        endcase
      end
    end

  always_ff @(posedge clk)
    if (push) begin
      s_pc[wp]  <= cur_pc;
      s_lvl[wp] <= level;
      s_sup[wp] <= sup_mode;
      s_gie[wp] <= gie;
    end
endmodule

// File: rtl/nest_irq_ctl_chk.sv
module nest_irq_ctl_chk #(
  parameter int DEPTH = 4,
  parameter int DPW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic           rte,
  input logic           redir_valid,
  input logic           sup_mode,
  input logic           gie,
  input logic [2:0]     level,
  input logic [DPW-1:0] depth,
  input logic           ovf
);
  p_depth_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DPW'(DEPTH));
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  p_entry_atomic_r4: assert property (@(posedge clk) disable iff (!rst_n)
    depth > $past(depth) |-> redir_valid && sup_mode && !gie);
  p_return_redir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    depth < $past(depth) |-> redir_valid);
  p_redir_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> depth != $past(depth));
  p_nested_sup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    depth != '0 |-> sup_mode);
  p_user_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_mode |-> level == 3'd0);
  p_user_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_mode && wr_en && !rte |=> gie == $past(gie) || depth != $past(depth));
endmodule

bind nest_irq_ctl nest_irq_ctl_chk #(.DEPTH(DEPTH), .DPW(DPW)) u_chk (.*);

// File: tb/sim_nest_irq_ctl.sv
`timescale 1ns/1ps
module sim_nest_irq_ctl;
  localparam int ND = 7;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [ND-1:0] dev_req = '0;
  logic exc_valid = 1'b0, trap_valid = 1'b0, rte = 1'b0, wr_en = 1'b0;
  logic [1:0] exc_cause = '0, trap_num = '0, wr_addr = '0;
  logic [31:0] cur_pc = '0;
  logic [ND-1:0] wr_data = '0;
  logic redir_valid, sup_mode, gie, ovf;
  logic [31:0] redir_pc;
  logic [2:0] level, depth;
  logic [ND-1:0] pend;

  int checks = 0, errors = 0;
  bit cmp_en = 1'b0;

  always #2 clk = ~clk;

  nest_irq_ctl u0 (.*);

  function automatic logic [31:0] vec(int c);
    return 32'h100 + 32'(c) * 4;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %0h exp %0h", tag, act, exp);
    end
  endtask

  // reference state
  bit m_sup, m_gie, m_ovf, m_rv;
  int m_lvl, m_sp;
  logic [ND-1:0] m_pend, m_mask;
  logic [31:0] m_rpc;
  logic [31:0] ms_pc [4];
  int ms_lvl [4];
  bit ms_sup [4], ms_gie [4];

  always @(posedge clk) begin : mdl
    logic [ND-1:0] clr;
    bit dh, want;
    int di;
    if (!rst_n) begin
      m_sup = 0; m_gie = 0; m_ovf = 0; m_rv = 0; m_lvl = 0; m_sp = 0;
      m_pend = '0; m_mask = '0; m_rpc = '0;
    end else begin
      dh = 0; di = 0; clr = '0; m_rv = 0;
      for (int i = 0; i < ND; i++)
        if (m_pend[i] && m_mask[i] && m_gie && (i + 1 > m_lvl)) begin dh = 1; di = i; end
      want = exc_valid | trap_valid | dh;
      if (rte) begin
        if (m_sp > 0) begin
          m_sp--; m_rv = 1; m_rpc = ms_pc[m_sp]; m_lvl = ms_lvl[m_sp];
          m_sup = ms_sup[m_sp]; m_gie = ms_gie[m_sp];
        end
      end else if (want) begin
        if (m_sp == 4) m_ovf = 1;
        else begin
          ms_pc[m_sp] = cur_pc; ms_lvl[m_sp] = m_lvl; ms_sup[m_sp] = m_sup; ms_gie[m_sp] = m_gie;
          m_sp++; m_rv = 1; m_sup = 1; m_gie = 0;
          if (exc_valid) m_rpc = vec(7 + int'(exc_cause));
          else if (trap_valid) m_rpc = vec(11 + int'(trap_num));
          else begin m_rpc = vec(di); m_lvl = di + 1; end
        end
      end else if (wr_en && m_sup) begin
        case (wr_addr)
          2'd0: m_gie = wr_data[0];
          2'd1: m_lvl = int'(wr_data[2:0]);
          2'd2: clr = wr_data;
          default: m_mask = wr_data;
        endcase
      end
      m_pend = (m_pend & ~clr) | dev_req;
    end
  end

  always @(negedge clk) if (cmp_en) begin
    chk("R4/R6 redirect valid", 32'(redir_valid), 32'(m_rv));
    if (m_rv) chk("R4/R6 redirect pc", redir_pc, m_rpc);
    chk("R4 mode", 32'(sup_mode), 32'(m_sup));
    chk("R7 enable", 32'(gie), 32'(m_gie));
    chk("R3 level", 32'(level), 32'(m_lvl));
    chk("R9 depth", 32'(depth), 32'(m_sp));
    chk("R2 pending", 32'(pend), 32'(m_pend));
    chk("R9 overflow", 32'(ovf), 32'(m_ovf));
  end

  task automatic idle();
    dev_req = '0; exc_valid = 0; trap_valid = 0; rte = 0; wr_en = 0;
  endtask

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [ND-1:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 0;
  endtask

  task automatic do_reset();
    cmp_en = 0;
    rst_n = 0;
    idle();
    cyc(3);
    rst_n = 1;
    cmp_en = 1;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog act running exp done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    chk("R1 redirect", 32'(redir_valid), 0);
    chk("R1 mode", 32'(sup_mode), 0);
    chk("R1 enable", 32'(gie), 0);
    chk("R1 level", 32'(level), 0);
    chk("R1 depth", 32'(depth), 0);
    chk("R1 pending", 32'(pend), 0);
    chk("R1 overflow", 32'(ovf), 0);

    wr(2'd0, 7'h01);
    chk("R8 user enable write", 32'(gie), 0);
    wr(2'd1, 7'h05);
    chk("R8 user level write", 32'(level), 0);

    trap_valid = 1; trap_num = 2'd2; cur_pc = 32'h40;
    cyc(); idle();
    chk("R5 trap vector", redir_pc, 32'h134);
    chk("R5 trap enters supervisor", 32'(sup_mode), 1);

    wr(2'd3, 7'h7f);
    wr(2'd0, 7'h01);
    chk("R7 enable write", 32'(gie), 1);

    dev_req = 7'h02; cur_pc = 32'h1000;
    cyc();
    chk("R2 pending set", 32'(pend), 32'h02);
    cyc();
    chk("R3 device vector", redir_pc, 32'h104);
    chk("R3 device level", 32'(level), 2);
    chk("R4 enable cleared", 32'(gie), 0);

    wr(2'd0, 7'h01);
    cyc();
    chk("R10 same level held", 32'(depth), 2);

    dev_req = 7'h12; cur_pc = 32'h2000;
    cyc(2);
    chk("R10 preempt vector", redir_pc, 32'h110);
    chk("R10 preempt level", 32'(level), 5);

    dev_req = '0;
    cyc();
    wr(2'd2, 7'h7f);
    chk("R2 pending cleared", 32'(pend), 0);
    rte = 1;
    cyc(); rte = 0;
    chk("R6 return pc", redir_pc, 32'h2000);
    chk("R6 level restored", 32'(level), 2);
    chk("R6 enable restored", 32'(gie), 1);

    exc_valid = 1; exc_cause = 2'd1;
    cyc();
    chk("R5 exception vector", redir_pc, 32'h120);
    cyc(2); idle();
    chk("R9 depth full", 32'(depth), 4);
    chk("R9 overflow set", 32'(ovf), 1);

    for (int k = 0; k < 6; k++) begin
      rte = 1; cyc(); rte = 0; cyc();
    end
    chk("R6 back to user", 32'(sup_mode), 0);

    for (int r = 0; r < 4; r++) begin
      do_reset();
      for (int k = 0; k < 1500; k++) begin
        dev_req    = ND'($urandom & $urandom & $urandom);
        exc_valid  = ($urandom % 24) == 0;
        exc_cause  = 2'($urandom);
        trap_valid = ($urandom % 24) == 0;
        trap_num   = 2'($urandom);
        rte        = ($urandom % 7) == 0;
        wr_en      = ($urandom % 3) == 0;
        wr_addr    = 2'($urandom);
        wr_data    = ND'($urandom);
        if (wr_addr == 2'd0) wr_data[0] = ($urandom % 4) != 0;
        if (wr_addr == 2'd1) wr_data[2:0] = 3'($urandom % 3);
        cur_pc     = $urandom & 32'hffff_fffc;
        cyc();
      end
      idle();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule